// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block is the write side of a small serial byte-wide non-volatile memory. A bus-protocol front end gives it byte-level events: a pulse that opens a write transaction and carries the 9-bit start address, one strobe for each data byte received, and a pulse when the closing stop condition is seen. The block holds the bytes of the transaction in a 16-slot page buffer. Each slot has a valid bit. At the stop it commits the valid slots to an internal 512 x 8 register array during a self-timed write cycle. While that cycle runs it raises `busy`, and the front end uses `busy` to withhold acknowledges.

Only the low four address bits advance after each byte. A long transaction therefore wraps inside its own 16-byte page, and later bytes replace earlier ones in the same slots. A write-protect input guards the upper half of the array. Guarded bytes are still accepted on the bus, but they never reach the array. A combinational read port lets the read path, and the bench, see the array contents.

Top module: `page_commit_engine`

## Requirements
- R1: After reset `busy` and `arr_we` are low and every array byte reads back as 0x00.
- R2: A transaction started at address A writes its k-th data byte (k from 0) to address {A[8:4], (A[3:0]+k) mod 16}. The upper five address bits never change inside a transaction.
- R3: When more than 16 data bytes arrive in one transaction, a later byte replaces the earlier byte held for the same slot. Only the last value for each slot is committed.
- R4: A stop ends an open transaction. If the transaction received no data byte, `busy` stays low and the array is unchanged, as in a dummy write before a random read.
- R5: A stop that ends a transaction with at least one data byte raises `busy` on the next clock. `busy` then stays high for exactly WR_CYCLES clock cycles. Array writes occur only while `busy` is high.
- R6: While `busy` is high, the start, data-strobe and stop inputs have no effect. A transaction attempted during the cycle leaves the array unchanged and starts no further busy period.
- R7: With `wp_upper` high when a byte arrives, a byte aimed at an address with bit 8 = 1 is discarded. Such a byte still counts as received for R5. Bytes aimed at bit 8 = 0 are written normally. With `wp_upper` low the whole array is writable.
- R8: Only the slots that received a byte are written. Every other location of the page keeps its previous value.
- R9: A new start pulse seen while a transaction is open discards all bytes buffered so far. Only the bytes of the new transaction are committed.
- R10: Commit writes happen one per clock, in ascending slot order, during the first 16 cycles of the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Opens a write transaction; samples `wr_addr` |
| wr_addr | input | 9 | Start byte address of the transaction |
| byte_stb | input | 1 | One received data byte |
| byte_data | input | 8 | Data byte qualified by `byte_stb` |
| stop_seen | input | 1 | Stop condition ended the transaction |
| wp_upper | input | 1 | High: guard addresses with bit 8 = 1 |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` (combinational) |
| busy | output | 1 | Self-timed write cycle in progress |
| arr_we | output | 1 | Array write strobe during the commit |
| arr_waddr | output | 9 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bound checker looks at every clock. It checks that array writes only happen inside a busy period, that each busy period has the exact configured length and follows a stop, that the page bits of the write address hold still during a commit, and that the slots written rise in order. Which bytes actually reach the array shows only in the bench scenarios. These cover the in-page wrap, overwrite after more than 16 bytes, a stop with no data, half-array protection, a restart discarding buffered bytes, and traffic ignored while busy. A behavioural reference model compared on every clock checks them, and readbacks of the array confirm them.

// File: rtl/pce_pkg.sv
package pce_pkg;
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_OPEN = 2'd1,
      PS_BUSY = 2'd2
   } pce_state_e;
endpackage

// File: rtl/pce_page_buf.sv
module pce_page_buf #(
   parameter int DATA_W = 8,
   parameter int SLOT_W = 4,
   localparam int SLOTS = 1 << SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [SLOT_W-1:0] off_in,
   input  logic              stb,
   input  logic              keep,
   input  logic [DATA_W-1:0] din,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [DATA_W-1:0] slot_data,
   output logic              slot_valid
);
   logic [SLOT_W-1:0] off_q;
   logic [DATA_W-1:0] data_q [SLOTS];
   logic [SLOTS-1:0]  vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   off_q <= '0;
      else if (clr) off_q <= off_in;
      else if (stb) off_q <= off_q + 1'b1;
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = stb && (off_q == SLOT_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q[s] <= '0;
            vld_q[s]  <= 1'b0;
         end else if (clr) begin
            vld_q[s]  <= 1'b0;
         end else if (hit) begin
            data_q[s] <= din;
            if (keep) vld_q[s] <= 1'b1;
         end
      end
   end

   assign slot_data  = data_q[rd_slot];
   assign slot_valid = vld_q[rd_slot];
endmodule

// File: rtl/pce_commit_seq.sv
module pce_commit_seq
   import pce_pkg::*;
#(
   parameter int SLOT_W    = 4,
   parameter int WR_CYCLES = 40,
   localparam int SLOTS = 1 << SLOT_W,
   localparam int CYC_W = $clog2(WR_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              byte_stb,
   input  logic              stop_seen,
   output logic              take_start,
   output logic              take_byte,
   output logic              busy,
   output logic              scan,
   output logic [SLOT_W-1:0] scan_slot
);
   pce_state_e       st_q;
   logic             got_q;
   logic [CYC_W-1:0] cnt_q;
   logic             take_stop;

   assign take_start = wr_start && (st_q != PS_BUSY);
   assign take_byte  = byte_stb && !wr_start && (st_q == PS_OPEN);
   assign take_stop  = stop_seen && !wr_start && !byte_stb && (st_q == PS_OPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PS_IDLE;
         got_q <= 1'b0;
         cnt_q <= '0;
      end else if (st_q == PS_BUSY) begin
         if (cnt_q == CYC_W'(WR_CYCLES - 1)) begin
            st_q  <= PS_IDLE;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (take_start) begin
         st_q  <= PS_OPEN;
         got_q <= 1'b0;
      end else if (take_byte) begin
         got_q <= 1'b1;
      end else if (take_stop) begin
         st_q  <= got_q ? PS_BUSY : PS_IDLE;
         cnt_q <= '0;
         got_q <= 1'b0;
      end
   end

   assign busy      = (st_q == PS_BUSY);
   assign scan      = busy && (cnt_q < CYC_W'(SLOTS));
   assign scan_slot = cnt_q[SLOT_W-1:0];
endmodule

// File: rtl/pce_store.sv
module pce_store #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
   parameter int ADDR_W     = 9,
   parameter int DATA_W     = 8,
   parameter int SLOT_W     = 4,
   parameter int WR_CYCLES  = 40,
   parameter int PROT_PAGES = (1 << (ADDR_W - SLOT_W)) / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              byte_stb,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop_seen,
   input  logic              wp_upper,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_waddr,
   output logic [DATA_W-1:0] arr_wdata
);
   localparam int PG_W      = ADDR_W - SLOT_W;
   localparam int NUM_PAGES = 1 << PG_W;
   localparam int SLOTS     = 1 << SLOT_W;
   localparam int FIRST_PROT = NUM_PAGES - PROT_PAGES;

   initial begin
      assert (WR_CYCLES >= SLOTS) else $error("WR_CYCLES must cover one page scan");
      assert (PROT_PAGES >= 0 && PROT_PAGES <= NUM_PAGES) else $error("PROT_PAGES out of range");
      assert (SLOT_W > 0 && SLOT_W < ADDR_W) else $error("SLOT_W must be below ADDR_W");
   end

   logic            take_start, take_byte, scan, slot_valid, guard;
   logic [SLOT_W-1:0] scan_slot;
   logic [PG_W-1:0]   page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          page_q <= '0;
      else if (take_start) page_q <= wr_addr[ADDR_W-1:SLOT_W];
   end

   if (PROT_PAGES == 0) begin : g_noprot
      assign guard = 1'b0;
   end else begin : g_prot
      assign guard = wp_upper && (page_q >= PG_W'(FIRST_PROT));
   end

   pce_commit_seq #(.SLOT_W(SLOT_W), .WR_CYCLES(WR_CYCLES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_start   (wr_start),
      .byte_stb   (byte_stb),
      .stop_seen  (stop_seen),
      .take_start (take_start),
      .take_byte  (take_byte),
      .busy       (busy),
      .scan       (scan),
      .scan_slot  (scan_slot)
   );

   pce_page_buf #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (take_start),
      .off_in     (wr_addr[SLOT_W-1:0]),
      .stb        (take_byte),
      .keep       (!guard),
      .din        (byte_data),
      .rd_slot    (scan_slot),
      .slot_data  (arr_wdata),
      .slot_valid (slot_valid)
   );

   assign arr_we    = scan && slot_valid;
   assign arr_waddr = {page_q, scan_slot};

   pce_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (arr_we),
      .waddr (arr_waddr),
      .wdata (arr_wdata),
      .raddr (rd_addr),
      .rdata (rd_data)
   );
endmodule

// File: rtl/pce_checker.sv
module pce_checker #(
   parameter int ADDR_W    = 9,
   parameter int SLOT_W    = 4,
   parameter int WR_CYCLES = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              stop_seen,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_waddr
);
   logic [31:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= '0;
   end

   a_r5_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   a_r5_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == 32'(WR_CYCLES)));

   a_r5_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < 32'(WR_CYCLES)));

   a_r4_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_seen));

   a_r2_page_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(arr_waddr[ADDR_W-1:SLOT_W]));

   a_r10_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |=> (!arr_we || (arr_waddr[SLOT_W-1:0] > $past(arr_waddr[SLOT_W-1:0]))));
endmodule

bind page_commit_engine pce_checker #(
   .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .WR_CYCLES(WR_CYCLES)
) u_pce_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .stop_seen (stop_seen),
   .arr_we    (arr_we),
   .arr_waddr (arr_waddr)
);

// File: tb/test_page_commit_engine.sv
`timescale 1ns/1ps
module test_page_commit_engine;
   localparam int WRC = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_start = 1'b0;
   logic [8:0] wr_addr = '0;
   logic       byte_stb = 1'b0;
   logic [7:0] byte_data = '0;
   logic       stop_seen = 1'b0;
   logic       wp_upper = 1'b0;
   logic [8:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       busy, arr_we;
   logic [8:0] arr_waddr;
   logic [7:0] arr_wdata;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   page_commit_engine #(.WR_CYCLES(WRC)) i_page_commit_engine (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
      .byte_stb(byte_stb), .byte_data(byte_data), .stop_seen(stop_seen),
      .wp_upper(wp_upper), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
      .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata));

   // behavioural reference model
   logic [7:0] m_mem [512];
   logic [7:0] m_buf [16];
   bit         m_mask [16];
   bit         m_open, m_busy, m_got;
   int         m_cnt, m_page, m_off;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
         for (int i = 0; i < 16; i++) begin m_buf[i] = 8'h00; m_mask[i] = 0; end
         m_open = 0; m_busy = 0; m_got = 0; m_cnt = 0; m_page = 0; m_off = 0;
      end else if (m_busy) begin
         if (m_cnt < 16 && m_mask[m_cnt]) m_mem[m_page*16 + m_cnt] = m_buf[m_cnt];
         if (m_cnt == WRC-1) begin m_busy = 0; m_open = 0; end
         else m_cnt++;
      end else if (wr_start) begin
         m_open = 1; m_got = 0;
         m_page = int'(wr_addr) / 16; m_off = int'(wr_addr) % 16;
         for (int i = 0; i < 16; i++) m_mask[i] = 0;
      end else if (m_open && byte_stb) begin
         m_buf[m_off] = byte_data;
         if (!(wp_upper && m_page >= 16)) m_mask[m_off] = 1;
         m_got = 1;
         m_off = (m_off + 1) % 16;
      end else if (m_open && stop_seen) begin
         m_open = 0;
         if (m_got) begin m_busy = 1; m_cnt = 0; end
      end
   end

   task automatic fail_line(string req, int act, int exp);
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      #3;
      if (rst_n) begin
         bit exp_we;
         exp_we = m_busy && m_cnt < 16 && m_mask[m_cnt];
         total++;
         if (busy !== m_busy) fail_line("R5 busy", int'(busy), int'(m_busy));
         total++;
         if (arr_we !== exp_we) fail_line("R8 arr_we", int'(arr_we), int'(exp_we));
         if (exp_we && arr_we) begin
            total++;
            if (arr_waddr !== 9'(m_page*16 + m_cnt)) fail_line("R2 arr_waddr", int'(arr_waddr), m_page*16 + m_cnt);
            total++;
            if (arr_wdata !== m_buf[m_cnt]) fail_line("R3 arr_wdata", int'(arr_wdata), int'(m_buf[m_cnt]));
         end
         total++;
         if (rd_data !== m_mem[rd_addr]) fail_line("R8 rd_data", int'(rd_data), int'(m_mem[rd_addr]));
      end
   end

   task automatic do_start(input logic [8:0] a);
      @(negedge clk); wr_start = 1'b1; wr_addr = a;
      @(negedge clk); wr_start = 1'b0;
   endtask

   task automatic send(input logic [7:0] d);
      @(negedge clk); byte_stb = 1'b1; byte_data = d;
      @(negedge clk); byte_stb = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk); stop_seen = 1'b1;
      @(negedge clk); stop_seen = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_mem(input logic [8:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); rd_addr = a;
      #1;
      total++;
      if (rd_data !== exp) fail_line(req, int'(rd_data), int'(exp));
   endtask

   task automatic check_bit(input logic act, input logic exp, input string req);
      total++;
      if (act !== exp) fail_line(req, int'(act), int'(exp));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check_bit(busy, 1'b0, "R1 busy after reset");
      check_bit(arr_we, 1'b0, "R1 arr_we after reset");
      rst_n = 1'b1;
      check_mem(9'h000, 8'h00, "R1 array cleared");
      check_mem(9'h1FF, 8'h00, "R1 array cleared");

      // R5: single byte, busy length
      begin
         int n;
         do_start(9'h005); send(8'h5A); do_stop();
         n = 0;
         while (busy) begin n++; @(negedge clk); end
         total++;
         if (n != WRC) fail_line("R5 busy length", n, WRC);
      end
      wait_idle();
      check_mem(9'h005, 8'h5A, "R5 byte committed");

      // R2: wrap within the page
      do_start(9'h03E);
      send(8'hA1); send(8'hA2); send(8'hA3); send(8'hA4);
      do_stop(); wait_idle();
      check_mem(9'h03E, 8'hA1, "R2 slot 14");
      check_mem(9'h03F, 8'hA2, "R2 slot 15");
      check_mem(9'h030, 8'hA3, "R2 wrap to slot 0");
      check_mem(9'h031, 8'hA4, "R2 wrap slot 1");
      check_mem(9'h040, 8'h00, "R2 next page untouched");
      // R8: partial page
      check_mem(9'h032, 8'h00, "R8 unsent slot kept");
      check_mem(9'h03D, 8'h00, "R8 unsent slot kept");

      // R3: 18 bytes overwrite
      do_start(9'h070);
      for (int k = 0; k < 18; k++) send(8'(8'h10 + k));
      do_stop(); wait_idle();
      check_mem(9'h070, 8'h20, "R3 slot 0 overwritten");
      check_mem(9'h071, 8'h21, "R3 slot 1 overwritten");
      check_mem(9'h072, 8'h12, "R3 slot 2 first value");
      check_mem(9'h07F, 8'h1F, "R3 slot 15");

      // R4: stop without data
      do_start(9'h100); do_stop();
      repeat (3) begin
         @(negedge clk);
         check_bit(busy, 1'b0, "R4 no busy after empty write");
      end
      check_mem(9'h100, 8'h00, "R4 array unchanged");

      // R7: protection
      wp_upper = 1'b1;
      do_start(9'h1A0); send(8'h55); do_stop();
      @(negedge clk);
      check_bit(busy, 1'b1, "R7 guarded byte still starts cycle");
      wait_idle();
      check_mem(9'h1A0, 8'h00, "R7 upper byte blocked");
      do_start(9'h0A0); send(8'h66); do_stop(); wait_idle();
      check_mem(9'h0A0, 8'h66, "R7 lower half writable under protect");
      wp_upper = 1'b0;
      do_start(9'h1A4); send(8'h77); do_stop(); wait_idle();
      check_mem(9'h1A4, 8'h77, "R7 upper writable without protect");

      // R6: inputs ignored while busy
      do_start(9'h0C0); send(8'h88); do_stop();
      do_start(9'h0C1); send(8'h99); do_stop();
      wait_idle();
      repeat (3) begin
         @(negedge clk);
         check_bit(busy, 1'b0, "R6 no second cycle");
      end
      check_mem(9'h0C0, 8'h88, "R6 first write done");
      check_mem(9'h0C1, 8'h00, "R6 write during busy ignored");

      // R9: restart discards buffered bytes
      do_start(9'h040); send(8'h11); send(8'h12);
      do_start(9'h050); send(8'h13); do_stop(); wait_idle();
      check_mem(9'h040, 8'h00, "R9 discarded slot 0");
      check_mem(9'h041, 8'h00, "R9 discarded slot 1");
      check_mem(9'h050, 8'h13, "R9 new transaction committed");

      // R10: full page in order (order checked per clock by the model)
      do_start(9'h0E0);
      for (int k = 0; k < 16; k++) send(8'(8'hC0 + k));
      do_stop(); wait_idle();
      check_mem(9'h0E0, 8'hC0, "R10 first slot");
      check_mem(9'h0EF, 8'hCF, "R10 last slot");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule